// File: doc/BRIEF.md
# Boundary-Checking Frame Deserializer

This block takes a serial bit stream, one bit per cycle of a recovered bit clock, and rebuilds 22-bit parallel words from 25-bit frames. Each frame carries a zero lead bit, then the 22 data bits with the least significant bit first, then two boundary bits. Both boundary bits must be the inverse of data bit 21, so every frame holds at least one level change. The block finds the frame boundary by sliding a 25-bit window over the stream. It keeps checking every frame once it has locked.

Each word that passes the check appears on `word_out` and is marked by `word_clk`. This strobe stands in for the recovered parallel clock: it idles high, drops for one bit cycle when a new word is loaded, and its rising edge marks the word as valid. If a frame fails while the block is locked, `link_fault` rises. This models the receiver pulling the link high to tell the sender. The block then powers down, with the data outputs held low and the strobe held high, and stays there until `pwr_up_req` returns it to hunting.

The controller has four states. HUNT slides the window one bit at a time. CONFIRM checks frames at a candidate alignment. LOCKED presents words. DOWN is power-down with the fault raised. The transitions are:
- HUNT→CONFIRM when a full window passes the frame test.
- CONFIRM→LOCKED when `LOCK_FRAMES` valid frames in a row have been seen at that alignment.
- CONFIRM→HUNT when a frame at the candidate alignment fails.
- LOCKED→DOWN when a frame fails.
- DOWN→HUNT on `pwr_up_req`.

Top module: `bdes_top`

## Requirements
- R1: Frame bit 0 is the lead bit and frame bits 1 to 22 are data bits 0 to 21; when a word is presented, `word_out[i]` equals frame bit i+1.
- R2: A frame is valid only if its lead bit is 0 and both boundary bits (frame bits 23 and 24) equal the inverse of data bit 21; a lead bit of 1 or a wrong boundary bit makes the frame invalid.
- R3: In HUNT the frame test is applied at every bit position once 25 bits have been received; lock needs 2 valid frames in a row at the same alignment; the first of them is not presented; a failed second frame returns to HUNT with no fault.
- R4: While locked, every frame is tested; an invalid frame raises `link_fault` at the clock edge that samples its last bit.
- R5: A word is loaded at the edge that samples the frame's last bit, with `word_clk` low for that one cycle; `word_clk` rises at the next edge with `word_out` unchanged; otherwise `word_clk` is high.
- R6: While powered down (`link_fault` high), `word_out` is all zeros and `word_clk` is high.
- R7: `link_fault` holds until `pwr_up_req` is seen in power-down, which clears it at that edge and enters HUNT, needing 25 fresh bits before the next frame test; `pwr_up_req` has no effect outside power-down.
- R8: After reset the block is in HUNT with `word_out` zero, `word_clk` high and `link_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data bit sampled each rising edge |
| pwr_up_req | input | 1 | Power-up request that leaves power-down |
| word_out | output | 22 | Recovered parallel word |
| word_clk | output | 1 | Word strobe; rising edge marks `word_out` valid |
| link_fault | output | 1 | Boundary fault and power-down indication |

## Verification
Every result comes from a register, so the bench checks it in the cycle after the edge that samples the frame's last bit. In that cycle the word, the low strobe and any fault all become visible. The strobe rise is checked one cycle later. The fault clear is checked in the cycle after the edge that samples `pwr_up_req`. The bench drives one bit per step on the falling edge and updates its own frame model for the coming rising edge. At the next falling edge it compares all three outputs against that model, and directed checks read the outputs at that same point after the frame's final bit.

// File: rtl/bdes_pkg.sv
package bdes_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_DOWN    = 2'd3
    } bdes_state_e;
endpackage

// File: rtl/bdes_window.sv
// Sliding frame window with a look-ahead validity test on the incoming bit.
module bdes_window #(
    parameter int DATA_W = 22,
    parameter int BND_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_in,
    output logic [1+DATA_W+BND_W-1:0]   win_next,
    output logic                        frame_ok
);
    localparam int FRAME_W = 1 + DATA_W + BND_W;

    logic [FRAME_W-1:0] win_q;
    logic [BND_W-1:0]   bnd_hit;

    // newest bit enters at the top, so the oldest (lead) bit sits at index 0
    assign win_next = {ser_in, win_q[FRAME_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_next;
    end

    for (genvar i = 0; i < BND_W; i++) begin : g_bnd
        assign bnd_hit[i] = win_next[DATA_W+1+i] ^ win_next[DATA_W];
    end

    assign frame_ok = !win_next[0] && (&bnd_hit);
endmodule

// File: rtl/bdes_ctrl.sv
// Alignment controller: hunt, confirm, locked, power-down.
module bdes_ctrl
    import bdes_pkg::*;
#(
    parameter int FRAME_W     = 25,
    parameter int LOCK_FRAMES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_ok,
    input  logic        pwr_up_req,
    output logic        emit,
    output logic        trip,
    output bdes_state_e state_q
);
    localparam int CNT_W  = $clog2(FRAME_W);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
    localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(FRAME_W - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_FRAMES - 1);

    bdes_state_e       state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [GOOD_W-1:0] good_q, good_d;
    logic              last;

    assign last = (cnt_q == LAST_POS);

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        good_d  = good_q;
        unique case (state_q)
            ST_HUNT: begin
                if (!last)        cnt_d = cnt_q + 1'b1;
                else if (frame_ok) begin
                    state_d = ST_CONFIRM;
                    cnt_d   = '0;
                    good_d  = GOOD_W'(1);
                end
            end
            ST_CONFIRM: begin
                if (!last)        cnt_d = cnt_q + 1'b1;
                else if (frame_ok) begin
                    cnt_d  = '0;
                    good_d = good_q + 1'b1;
                    if (good_q == GOOD_LAST) state_d = ST_LOCKED;
                end else begin
                    state_d = ST_HUNT;  // window stays full: keep sliding
                end
            end
            ST_LOCKED: begin
                if (!last)         cnt_d = cnt_q + 1'b1;
                else if (frame_ok) cnt_d = '0;
                else               state_d = ST_DOWN;
            end
            ST_DOWN: begin
                if (pwr_up_req) begin
                    state_d = ST_HUNT;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            good_q  <= good_d;
        end
    end

    // output process
    always_comb begin
        emit = 1'b0;
        trip = 1'b0;
        unique case (state_q)
            ST_HUNT:    ;
            ST_CONFIRM: emit = last && frame_ok && (good_q == GOOD_LAST);
            ST_LOCKED: begin
                emit = last && frame_ok;
                trip = last && !frame_ok;
            end
            ST_DOWN:    ;
        endcase
    end
endmodule

// File: rtl/bdes_outreg.sv
// Parallel word register and word strobe.
module bdes_outreg #(
    parameter int DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              trip,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] word_q,
    output logic              strobe_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            strobe_q <= 1'b1;
        end else begin
            strobe_q <= !emit;
            if (trip)      word_q <= '0;
            else if (emit) word_q <= data_in;
        end
    end
endmodule

// File: rtl/bdes_top.sv
module bdes_top
    import bdes_pkg::*;
#(
    parameter int DATA_W      = 22,
    parameter int BND_W       = 2,
    parameter int LOCK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              pwr_up_req,
    output logic [DATA_W-1:0] word_out,
    output logic              word_clk,
    output logic              link_fault
);
    localparam int FRAME_W = 1 + DATA_W + BND_W;

    logic [FRAME_W-1:0] win_next;
    logic               frame_ok;
    logic               emit;
    logic               trip;
    bdes_state_e        st;

    bdes_window #(.DATA_W(DATA_W), .BND_W(BND_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .win_next (win_next),
        .frame_ok (frame_ok)
    );

    bdes_ctrl #(.FRAME_W(FRAME_W), .LOCK_FRAMES(LOCK_FRAMES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ok   (frame_ok),
        .pwr_up_req (pwr_up_req),
        .emit       (emit),
        .trip       (trip),
        .state_q    (st)
    );

    bdes_outreg #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .trip     (trip),
        .data_in  (win_next[DATA_W:1]),
        .word_q   (word_out),
        .strobe_q (word_clk)
    );

    assign link_fault = (st == ST_DOWN);
endmodule

// File: rtl/bdes_checker.sv
module bdes_checker
    import bdes_pkg::*;
#(
    parameter int DATA_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_up_req,
    input logic [DATA_W-1:0] word_out,
    input logic              word_clk,
    input logic              link_fault,
    input bdes_state_e       st
);
    p_down_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_fault |-> (word_out == '0) && word_clk);

    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fault && !pwr_up_req) |=> link_fault);

    p_fault_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fault && pwr_up_req) |=> (!link_fault && st == ST_HUNT));

    p_strobe_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_clk |-> (st == ST_LOCKED));

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_clk |=> word_clk);

    p_stable_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_clk) |-> $stable(word_out));

    p_word_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> (!word_clk || link_fault));

    p_fault_from_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_fault) |-> ($past(st) == ST_LOCKED));
endmodule

bind bdes_top bdes_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_up_req (pwr_up_req),
    .word_out   (word_out),
    .word_clk   (word_clk),
    .link_fault (link_fault),
    .st         (st)
);

// File: tb/bdes_top_test.sv
module bdes_top_test;
    localparam int CLK_P = 10;
    localparam int LOCKN = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ser_in;
    logic        pwr_up_req;
    logic [21:0] word_out;
    logic        word_clk;
    logic        link_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [24:0] mw;
    int          mmode;   // 0 hunt, 1 confirm, 2 locked, 3 down
    int          mfill, mpos, mgood;
    logic [21:0] exp_word;
    logic        exp_clk, exp_fault;

    always #(CLK_P/2) clk = ~clk;

    bdes_top uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .pwr_up_req(pwr_up_req),
        .word_out(word_out), .word_clk(word_clk), .link_fault(link_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // frame rule from R2: lead 0, both boundary bits inverse of data bit 21
    function automatic bit frame_valid(input logic [24:0] f);
        return (f[0] == 1'b0) && (f[23] != f[22]) && (f[24] != f[22]);
    endfunction

    task automatic model(input logic b, input logic p);
        logic [24:0] nw;
        nw = {b, mw[24:1]};
        mw = nw;
        exp_clk = 1'b1;
        if (mmode == 3) begin
            if (p) begin mmode = 0; mfill = 0; exp_fault = 1'b0; end
        end else if (mmode == 0) begin
            if (mfill < 24) mfill++;
            else if (frame_valid(nw)) begin mmode = 1; mpos = 0; mgood = 1; end
        end else if (mpos < 24) begin
            mpos++;
        end else if (frame_valid(nw)) begin
            mpos = 0;
            if (mmode == 1) mgood++;
            if (mmode == 2 || mgood == LOCKN) begin
                mmode = 2; exp_word = nw[22:1]; exp_clk = 1'b0;
            end
        end else if (mmode == 1) begin
            mmode = 0; mfill = 24;
        end else begin
            mmode = 3; exp_fault = 1'b1; exp_word = '0;
        end
    endtask

    task automatic cmp();
        chk("R1 word_out", 32'(word_out), 32'(exp_word));
        chk("R5 word_clk", 32'(word_clk), 32'(exp_clk));
        chk("R4 link_fault", 32'(link_fault), 32'(exp_fault));
    endtask

    task automatic step(input logic b, input logic p);
        cmp();
        ser_in = b;
        pwr_up_req = p;
        model(b, p);
        @(negedge clk);
    endtask

    task automatic tail(input logic [21:0] d, input logic b1, input logic b2);
        for (int i = 0; i < 22; i++) step(d[i], 1'b0);
        step(b1, 1'b0);
        step(b2, 1'b0);
    endtask

    task automatic good_frame(input logic [21:0] d);
        step(1'b0, 1'b0);
        tail(d, ~d[21], ~d[21]);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8 act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [21:0] d;
        void'($urandom(32'd1234));
        rst_n = 1'b0; ser_in = 1'b0; pwr_up_req = 1'b0;
        mw = '0; mmode = 0; mfill = 0; mpos = 0; mgood = 0;
        exp_word = '0; exp_clk = 1'b1; exp_fault = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reset word_out", 32'(word_out), 32'h0);
        chk("R8 reset word_clk", 32'(word_clk), 32'h1);
        chk("R8 reset link_fault", 32'(link_fault), 32'h0);
        rst_n = 1'b1;

        // lock: first valid frame not presented, second is (R3)
        good_frame(22'h13A5C7);
        chk("R3 no word after first frame", 32'(word_clk), 32'h1);
        good_frame(22'h0F0F0F);
        chk("R3 word after lock", 32'(word_out), 32'h0F0F0F);
        chk("R3 strobe low after lock", 32'(word_clk), 32'h0);
        good_frame(22'h2AAAA5);
        chk("R1 bit order", 32'(word_out), 32'h2AAAA5);

        // boundary error while locked (R2, R4, R6)
        step(1'b0, 1'b0);
        tail(22'h3FFFFF, 1'b0, 1'b1);
        chk("R4 fault raised", 32'(link_fault), 32'h1);
        chk("R6 word zero in power-down", 32'(word_out), 32'h0);
        chk("R6 strobe high in power-down", 32'(word_clk), 32'h1);
        for (int i = 0; i < 30; i++) step(1'($urandom), 1'b0);
        chk("R7 fault held", 32'(link_fault), 32'h1);

        // wake and relock (R7, R3)
        step(1'b1, 1'b1);
        chk("R7 fault cleared", 32'(link_fault), 32'h0);
        good_frame(22'h155555);
        good_frame(22'h2DEAD1);
        chk("R3 relock word", 32'(word_out), 32'h2DEAD1);
        step(1'b0, 1'b1);
        tail(22'h012345, 1'b1, 1'b1);
        chk("R7 request ignored when locked", 32'(word_out), 32'h012345);
        chk("R7 no fault from request", 32'(link_fault), 32'h0);

        // lead bit of 1 is invalid (R2)
        step(1'b1, 1'b0);
        tail(22'h0ABCDE, 1'b1, 1'b1);
        chk("R2 lead bit one faults", 32'(link_fault), 32'h1);

        // failed confirmation goes back to hunt without fault (R3)
        step(1'b0, 1'b1);
        good_frame(22'h1C3C3C);
        step(1'b0, 1'b0);
        tail(22'h200001, 1'b1, 1'b0);
        chk("R3 confirm fail no fault", 32'(link_fault), 32'h0);
        chk("R3 confirm fail no word", 32'(word_clk), 32'h1);

        // constrained random traffic, compared against the model every cycle
        for (int f = 0; f < 300; f++) begin
            int junk;
            int kind;
            junk = ($urandom % 4 == 0) ? int'($urandom % 5) : 0;
            for (int j = 0; j < junk; j++) step(1'($urandom), 1'b0);
            d = 22'($urandom);
            kind = int'($urandom % 12);
            step((kind == 0) ? 1'b1 : 1'b0, ($urandom % 40 == 0) ? 1'b1 : 1'b0);
            tail(d, (kind == 1) ? d[21] : ~d[21], (kind == 2) ? d[21] : ~d[21]);
            if (exp_fault && ($urandom % 2 == 0)) step(1'($urandom), 1'b1);
        end
        cmp();

        done = 1;
        summary();
        $finish;
    end
endmodule